// File: doc/BRIEF.md
# Half-Duplex Transmit Deferral and Backoff Sequencer

This block decides when a 10 Mb/s half-duplex MAC may put a frame on the wire. One clock cycle equals one bit time. A start request carries the frame length in bit times. The sequencer watches carrier sense and enforces the inter-frame gap before it raises the transmit enable. It counts down the frame length as a stand-in for the data path. If the line reports a collision, the sequencer sends a jam. It then draws a random number of slot times with truncated binary exponential backoff, and retries after that wait.

The gap can be deferred in two ways, chosen per frame by an input. In the two-part style, carrier seen in the first part of the gap restarts the gap and carrier in the last part is ignored. In the simple style, any carrier before the gap completes restarts it. A collision inside the first slot time of a frame leads to a retry. A collision after the slot boundary ends the frame as a late collision. After sixteen collisions on one frame, the frame is abandoned and an excessive-collision event is raised. Each outcome appears as a one-cycle event pulse.

Top module: `mac_tx_defer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `tx_en`, `jam_on` and all three event outputs are low. After reset the gap counter is cleared, so a full gap must elapse before the first frame.
- R2: When the line has been quiet for at least a full gap, `tx_en` rises in the second cycle after `req_start` is sampled high. It stays high for exactly `req_bits` cycles, and `ev_done` is high for the single cycle that follows.
- R3: With a frame pending, `tx_en` rises IPG_BITS+1 cycles after the last cycle in which `carrier` was sampled high. The block's own transmission or jam also restarts the gap.
- R4: In two-part mode (`simple_defer`=0), carrier sampled while the gap count is below GAP_PART1 restarts the gap. Carrier sampled at a count of GAP_PART1 or more is ignored.
- R5: In simple mode (`simple_defer`=1), carrier sampled at any point before the gap completes restarts the gap.
- R6: A collision sampled during transmit bit b, with b < SLOT_BITS, makes `jam_on` (together with `tx_en`) high from the next cycle for exactly JAM_BITS cycles.
- R7: After the n-th collision on a frame, `tx_en` stays low for exactly max(IPG_BITS+1, r*SLOT_BITS+2) cycles before the retry. Here r is an integer with 0 <= r <= 2^min(n,BO_CAP)-1, drawn from an internal LFSR. No event is raised between attempts.
- R8: When collision number MAX_TRIES of a frame has been jammed, `ev_excess` pulses in the cycle after the jam and the frame is not retried.
- R9: A collision sampled at transmit bit b >= SLOT_BITS is jammed as in R6. Then `ev_late` pulses in the cycle after the jam and the frame is not retried.
- R10: `collision` outside transmission has no effect. So do `req_start` while a frame is in progress, and `req_start` with `req_bits`=0.
- R11: Each event output is a one-cycle pulse, and no two events are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start request for a new frame, sampled while idle |
| req_bits | input | LEN_W | Frame length in bit times, latched with the request |
| simple_defer | input | 1 | 1 = simple deferral, 0 = two-part deferral |
| carrier | input | 1 | Carrier sense from the line |
| collision | input | 1 | Collision detect from the line |
| tx_en | output | 1 | High while frame bits or jam are driven |
| jam_on | output | 1 | High while the jam is driven |
| ev_done | output | 1 | Pulse: frame sent without collision |
| ev_excess | output | 1 | Pulse: frame dropped after too many collisions |
| ev_late | output | 1 | Pulse: frame dropped after a late collision |

## Verification
The bench places carrier bumps one count on each side of the two-part boundary and at the same count in simple mode. A sequencer that compared with the wrong bound would restart or ignore the gap and move the transmit start by many cycles. It places collisions on the last bit before the slot boundary and on the first bit after it. An off-by-one there would retry a late collision or abandon a normal one. Each retry gap is checked to be either the bare gap or an exact slot multiple inside the window allowed by the collision count, which catches a wrong range mask or a miscounted slot. The bench runs fifteen collisions followed by a success, and sixteen collisions followed by the drop, to pin the attempt limit.

// File: rtl/mtd_pkg.sv
package mtd_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_DEFER,
      SQ_SEND,
      SQ_JAM,
      SQ_BACKOFF
   } sq_state_e;

   // bits needed to hold values 0 .. n-1, never less than one
   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/mtd_gap_timer.sv
module mtd_gap_timer #(
   parameter int unsigned IPG_BITS   = 96,
   parameter int unsigned PART1_BITS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic own_tx,
   input  logic carrier,
   input  logic simple_mode,
   input  logic frame_pending,
   output logic gap_done
);

   localparam int unsigned GW = mtd_pkg::cnt_bits(IPG_BITS + 1);
   localparam logic [GW-1:0] GAP_END = GW'(IPG_BITS);
   localparam logic [GW-1:0] P1_END  = GW'(PART1_BITS);

   generate
      if (PART1_BITS == 0 || PART1_BITS >= IPG_BITS) begin : g_bad_split
         $error("gap timer: PART1_BITS must lie strictly inside the gap");
      end
   endgenerate

   logic [GW-1:0] cnt_q;
   logic          complete;
   logic          in_part1;
   logic          restart;

   assign complete = (cnt_q == GAP_END);
   assign in_part1 = (cnt_q < P1_END);

   // restart rules: own activity always; carrier depends on deferral style;
   // a completed gap with nothing to send re-arms on any new carrier
   assign restart = own_tx
                  | (carrier & (simple_mode ? ~complete : in_part1))
                  | (carrier & complete & ~frame_pending);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (!complete) begin
         cnt_q <= cnt_q + GW'(1);
      end
   end

   assign gap_done = complete;

   // R4
   late_part_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!simple_mode && !own_tx && !in_part1 && !complete) |=> (cnt_q > $past(cnt_q)));

   // R5
   simple_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (simple_mode && carrier && !complete) |=> (cnt_q == '0));

endmodule

// File: rtl/mtd_lfsr.sv
module mtd_lfsr #(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned OUT_W = 10,
   parameter logic [31:0] SEED  = 32'h0000_ACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [OUT_W-1:0] value
);

   localparam logic [WIDTH-1:0] SEED_W = WIDTH'(SEED);

   logic [WIDTH-1:0] taps;
   logic [WIDTH-1:0] state_q;

   generate
      if (WIDTH == 16) begin : g_w16
         assign taps = WIDTH'(32'h0000_B400);
      end else if (WIDTH == 32) begin : g_w32
         assign taps = WIDTH'(32'h8020_0003);
      end else begin : g_bad_width
         $error("lfsr: WIDTH must be 16 or 32");
         assign taps = '0;
      end
      if (OUT_W > WIDTH) begin : g_bad_out
         $error("lfsr: OUT_W exceeds WIDTH");
      end
      if (SEED_W == '0) begin : g_bad_seed
         $error("lfsr: seed must be nonzero");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEED_W;
      end else begin
         state_q <= {1'b0, state_q[WIDTH-1:1]} ^ (state_q[0] ? taps : '0);
      end
   end

   assign value = state_q[OUT_W-1:0];

   // R7
   lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0);

endmodule

// File: rtl/mtd_backoff.sv
module mtd_backoff #(
   parameter int unsigned SLOT_BITS = 512,
   parameter int unsigned BO_CAP    = 10,
   parameter int unsigned ATT_W     = 5,
   parameter int unsigned LFSR_W    = 16,
   parameter logic [31:0] SEED      = 32'h0000_ACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic [ATT_W-1:0] attempts,
   output logic             expired
);

   localparam int unsigned SW = mtd_pkg::cnt_bits(SLOT_BITS);
   localparam logic [SW-1:0] SLOT_LAST = SW'(SLOT_BITS - 1);

   generate
      if (SLOT_BITS < 2) begin : g_bad_slot
         $error("backoff: SLOT_BITS must be at least 2");
      end
      if (BO_CAP == 0 || BO_CAP > LFSR_W) begin : g_bad_cap
         $error("backoff: BO_CAP must be 1 .. LFSR_W");
      end
   endgenerate

   logic [BO_CAP-1:0] rnd;
   logic [BO_CAP-1:0] range_mask;
   logic [BO_CAP-1:0] draw;
   logic [BO_CAP-1:0] slots_q;
   logic [SW-1:0]     sub_q;

   mtd_lfsr #(
      .WIDTH (LFSR_W),
      .OUT_W (BO_CAP),
      .SEED  (SEED)
   ) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .value (rnd)
   );

   // bit i of the range is open once more than i collisions happened,
   // which caps the exponent at BO_CAP automatically
   generate
      for (genvar i = 0; i < BO_CAP; i++) begin : g_mask
         assign range_mask[i] = (32'(attempts) > 32'(i));
      end
   endgenerate

   assign draw = rnd & range_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slots_q <= '0;
         sub_q   <= '0;
      end else if (load) begin
         slots_q <= draw;
         sub_q   <= '0;
      end else if (run && slots_q != '0) begin
         if (sub_q == SLOT_LAST) begin
            sub_q   <= '0;
            slots_q <= slots_q - BO_CAP'(1);
         end else begin
            sub_q <= sub_q + SW'(1);
         end
      end
   end

   assign expired = (slots_q == '0);

   // R7
   bo_draw_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> ((slots_q & ~$past(range_mask)) == '0));

   // R7
   bo_count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && !expired) |=> (slots_q <= $past(slots_q)));

endmodule

// File: rtl/mac_tx_defer.sv
module mac_tx_defer #(
   parameter int unsigned IPG_BITS  = 96,
   parameter int unsigned GAP_PART1 = 64,
   parameter int unsigned SLOT_BITS = 512,
   parameter int unsigned JAM_BITS  = 32,
   parameter int unsigned MAX_TRIES = 16,
   parameter int unsigned BO_CAP    = 10,
   parameter int unsigned LEN_W     = 14,
   parameter int unsigned LFSR_W    = 16,
   parameter logic [31:0] LFSR_SEED = 32'h0000_ACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_start,
   input  logic [LEN_W-1:0] req_bits,
   input  logic             simple_defer,
   input  logic             carrier,
   input  logic             collision,
   output logic             tx_en,
   output logic             jam_on,
   output logic             ev_done,
   output logic             ev_excess,
   output logic             ev_late
);

   import mtd_pkg::*;

   localparam int unsigned ATT_W = cnt_bits(MAX_TRIES + 1);
   localparam int unsigned JW    = cnt_bits(JAM_BITS);
   localparam logic [ATT_W-1:0] TRY_LIMIT = ATT_W'(MAX_TRIES);
   localparam logic [JW-1:0]    JAM_LAST  = JW'(JAM_BITS - 1);

   generate
      if (JAM_BITS == 0) begin : g_bad_jam
         $error("mac_tx_defer: JAM_BITS must be nonzero");
      end
      if (MAX_TRIES == 0) begin : g_bad_tries
         $error("mac_tx_defer: MAX_TRIES must be nonzero");
      end
   endgenerate

   sq_state_e        state_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] bit_q;
   logic [JW-1:0]    jam_q;
   logic [ATT_W-1:0] tries_q;
   logic             late_q;
   logic             done_q;
   logic             excess_q;
   logic             latev_q;

   logic gap_done;
   logic bo_expired;
   logic jam_last;
   logic bo_load;
   logic is_late_bit;

   assign tx_en       = (state_q == SQ_SEND) || (state_q == SQ_JAM);
   assign jam_on      = (state_q == SQ_JAM);
   assign jam_last    = (jam_q == JAM_LAST);
   assign is_late_bit = (32'(bit_q) >= SLOT_BITS);
   assign bo_load     = (state_q == SQ_JAM) && jam_last && !late_q && (tries_q != TRY_LIMIT);

   mtd_gap_timer #(
      .IPG_BITS   (IPG_BITS),
      .PART1_BITS (GAP_PART1)
   ) u_gap (
      .clk           (clk),
      .rst_n         (rst_n),
      .own_tx        (tx_en),
      .carrier       (carrier),
      .simple_mode   (simple_defer),
      .frame_pending (state_q != SQ_IDLE),
      .gap_done      (gap_done)
   );

   mtd_backoff #(
      .SLOT_BITS (SLOT_BITS),
      .BO_CAP    (BO_CAP),
      .ATT_W     (ATT_W),
      .LFSR_W    (LFSR_W),
      .SEED      (LFSR_SEED)
   ) u_bo (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (bo_load),
      .run      (state_q == SQ_BACKOFF),
      .attempts (tries_q),
      .expired  (bo_expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         len_q    <= '0;
         bit_q    <= '0;
         jam_q    <= '0;
         tries_q  <= '0;
         late_q   <= 1'b0;
         done_q   <= 1'b0;
         excess_q <= 1'b0;
         latev_q  <= 1'b0;
      end else begin
         done_q   <= 1'b0;
         excess_q <= 1'b0;
         latev_q  <= 1'b0;
         case (state_q)
            SQ_IDLE: begin
               if (req_start && req_bits != '0) begin
                  state_q <= SQ_DEFER;
                  len_q   <= req_bits;
                  tries_q <= '0;
               end
            end
            SQ_DEFER: begin
               if (gap_done) begin
                  state_q <= SQ_SEND;
                  bit_q   <= '0;
               end
            end
            SQ_SEND: begin
               if (collision) begin
                  state_q <= SQ_JAM;
                  jam_q   <= '0;
                  late_q  <= is_late_bit;
                  if (!is_late_bit) begin
                     tries_q <= tries_q + ATT_W'(1);
                  end
               end else if (bit_q == len_q - LEN_W'(1)) begin
                  state_q <= SQ_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  bit_q <= bit_q + LEN_W'(1);
               end
            end
            SQ_JAM: begin
               if (jam_last) begin
                  if (late_q) begin
                     state_q <= SQ_IDLE;
                     latev_q <= 1'b1;
                  end else if (tries_q == TRY_LIMIT) begin
                     state_q  <= SQ_IDLE;
                     excess_q <= 1'b1;
                  end else begin
                     state_q <= SQ_BACKOFF;
                  end
               end else begin
                  jam_q <= jam_q + JW'(1);
               end
            end
            SQ_BACKOFF: begin
               if (bo_expired) begin
                  state_q <= SQ_DEFER;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign ev_done   = done_q;
   assign ev_excess = excess_q;
   assign ev_late   = latev_q;

   // R3
   tx_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_en) |-> $past(gap_done));

   // R6
   jam_after_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(jam_on) |-> ($past(collision) && $past(tx_en)));

   // R11
   ev_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_done, ev_excess, ev_late}));

   // R2
   done_after_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_done |-> ($past(tx_en) && !$past(jam_on) && !tx_en));

   // R8
   excess_after_jam_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_excess |-> ($past(jam_on) && !tx_en));

   // R9
   late_after_jam_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_late |-> ($past(jam_on) && !tx_en));

endmodule

// File: tb/mac_tx_defer_test.sv
module mac_tx_defer_test;

   localparam int CLK_PERIOD = 10;
   localparam int IPG   = 24;
   localparam int P1    = 16;
   localparam int SLOT  = 8;
   localparam int JAM   = 8;
   localparam int TRIES = 16;
   localparam int CAP   = 10;
   localparam int LW    = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_start = 1'b0;
   logic [LW-1:0] req_bits = '0;
   logic          simple_defer = 1'b0;
   logic          carrier = 1'b0;
   logic          collision = 1'b0;
   logic          tx_en, jam_on, ev_done, ev_excess, ev_late;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mac_tx_defer #(
      .IPG_BITS (IPG), .GAP_PART1 (P1), .SLOT_BITS (SLOT), .JAM_BITS (JAM),
      .MAX_TRIES (TRIES), .BO_CAP (CAP), .LEN_W (LW)
   ) uut (
      .clk (clk), .rst_n (rst_n), .req_start (req_start), .req_bits (req_bits),
      .simple_defer (simple_defer), .carrier (carrier), .collision (collision),
      .tx_en (tx_en), .jam_on (jam_on), .ev_done (ev_done),
      .ev_excess (ev_excess), .ev_late (ev_late)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // legal idle length after the n-th collision
   function automatic bit bo_idle_ok(input int g, input int n);
      int k = (n < CAP) ? n : CAP;
      int rmax = (1 << k) - 1;
      if (g == IPG + 1) return 1'b1;
      if (g <= IPG + 1) return 1'b0;
      if ((g - 2) % SLOT != 0) return 1'b0;
      return ((g - 2) / SLOT) <= rmax;
   endfunction

   task automatic quiet(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_frame(input int len, input bit simple, input int ncol,
                           input int colpos, input string tag);
      int attempt = 0;
      bit fin = 1'b0;
      simple_defer = simple;
      req_bits = LW'(len);
      req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      while (!fin) begin
         int g = 0;
         int b = 0;
         while (!tx_en && g < 20000) begin
            g++;
            @(negedge clk);
         end
         if (attempt == 0) check(g == 1, {"R2 start latency ", tag}, g, 1);
         else check(bo_idle_ok(g, attempt), {"R7 backoff idle ", tag}, g, IPG + 1);
         while (tx_en && !jam_on) begin
            if (attempt < ncol && b == colpos) collision = 1'b1;
            @(negedge clk);
            collision = 1'b0;
            b++;
         end
         if (jam_on) begin
            int jl = 0;
            check(attempt < ncol && b == colpos + 1, {"R6 jam start ", tag}, b, colpos + 1);
            while (jam_on && jl < 1000) begin
               jl++;
               @(negedge clk);
            end
            check(jl == JAM, {"R6 jam length ", tag}, jl, JAM);
            attempt++;
            if (colpos >= SLOT) begin
               check(ev_late && !tx_en, {"R9 late event ", tag}, ev_late, 1);
               fin = 1'b1;
            end else if (attempt == TRIES) begin
               check(ev_excess && !tx_en, {"R8 excess event ", tag}, ev_excess, 1);
               fin = 1'b1;
            end else begin
               check(!ev_late && !ev_excess && !ev_done, {"R7 no event between tries ", tag},
                     int'(ev_late) + int'(ev_excess) + int'(ev_done), 0);
            end
         end else begin
            check(!(attempt < ncol && colpos < len), {"R6 collision missed ", tag}, attempt, ncol);
            check(b == len, {"R2 frame length ", tag}, b, len);
            check(ev_done && !ev_excess && !ev_late, {"R2 done pulse ", tag}, ev_done, 1);
            fin = 1'b1;
         end
      end
      @(negedge clk);
      check(!ev_done && !ev_excess && !ev_late, {"R11 single-cycle event ", tag},
            int'(ev_done) + int'(ev_excess) + int'(ev_late), 0);
      quiet(IPG + 4);
   endtask

   task automatic finish_ok(input int len, input string tag);
      int b = 1;
      while (tx_en && b < 5000) begin
         @(negedge clk);
         if (tx_en) b++;
      end
      check(b == len && ev_done, {"R2 frame end ", tag}, b, len);
      quiet(IPG + 4);
   endtask

   // carrier held, request issued, optional one-cycle carrier bump w cycles
   // after the drop; expn counts cycles from the last carrier change to tx
   task automatic carrier_case(input bit simple, input int w, input int expn, input string tag);
      int n = 0;
      bit stayed_low = 1'b1;
      simple_defer = simple;
      carrier = 1'b1;
      req_bits = LW'(6);
      req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      collision = 1'b1;
      @(negedge clk);
      collision = 1'b0;
      repeat (6) begin
         @(negedge clk);
         stayed_low &= !tx_en && !jam_on;
      end
      check(stayed_low, {"R10 no tx under carrier or stray collision ", tag}, int'(!stayed_low), 0);
      carrier = 1'b0;
      if (w >= 0) begin
         repeat (w) @(negedge clk);
         carrier = 1'b1;
         @(negedge clk);
         carrier = 1'b0;
      end
      do begin
         @(negedge clk);
         n++;
      end while (!tx_en && n < 5000);
      check(n == expn, tag, n, expn);
      finish_ok(6, tag);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      bit quiet_ok;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check(!tx_en && !jam_on && !ev_done && !ev_excess && !ev_late, "R1 outputs in reset",
            int'(tx_en), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!tx_en && !jam_on && !ev_done && !ev_excess && !ev_late, "R1 outputs after reset",
            int'(tx_en), 0);
      quiet(IPG + 4);

      // R2 plain frames
      do_frame(5, 1'b0, 0, 0, "R2 short");
      do_frame(1, 1'b1, 0, 0, "R2 single bit");

      // R3 gap after carrier, R4 two-part boundary, R5 simple mode
      carrier_case(1'b0, -1, IPG + 1, "R3 gap after carrier");
      carrier_case(1'b0, P1 - 1, IPG + 1, "R4 early bump restarts");
      carrier_case(1'b0, P1, IPG + 1 - (P1 + 1), "R4 bump at boundary ignored");
      carrier_case(1'b0, P1 + 4, IPG + 1 - (P1 + 5), "R4 late bump ignored");
      carrier_case(1'b1, P1, IPG + 1, "R5 simple bump restarts");
      carrier_case(1'b1, P1 + 4, IPG + 1, "R5 simple late bump restarts");

      // R10 collision while idle, start during a frame, zero length
      collision = 1'b1;
      @(negedge clk);
      collision = 1'b0;
      quiet_ok = 1'b1;
      repeat (IPG) begin
         @(negedge clk);
         quiet_ok &= !tx_en && !jam_on && !ev_late && !ev_excess;
      end
      check(quiet_ok, "R10 idle collision ignored", int'(!quiet_ok), 0);

      req_bits = LW'(12);
      req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      @(negedge clk);
      check(tx_en, "R2 busy test start", int'(tx_en), 1);
      @(negedge clk);
      req_bits = LW'(3);
      req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      while (tx_en) @(negedge clk);
      quiet_ok = 1'b1;
      repeat (3 * IPG) begin
         @(negedge clk);
         quiet_ok &= !tx_en;
      end
      check(quiet_ok, "R10 start while busy ignored", int'(!quiet_ok), 0);

      req_bits = '0;
      req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      quiet_ok = 1'b1;
      repeat (2 * IPG) begin
         @(negedge clk);
         quiet_ok &= !tx_en && !ev_done;
      end
      check(quiet_ok, "R10 zero length ignored", int'(!quiet_ok), 0);

      // R6 / R9 slot boundary, R7 retries, R8 attempt limit
      do_frame(20, 1'b0, 1, SLOT - 1, "R6 last normal bit");
      do_frame(20, 1'b0, 1, SLOT, "R9 first late bit");
      do_frame(30, 1'b1, 1, 25, "R9 deep late");
      do_frame(6, 1'b0, 3, 0, "R7 three retries");
      do_frame(5, 1'b1, TRIES - 1, 0, "R8 one below limit");
      do_frame(5, 1'b0, TRIES, 2, "R8 limit reached");

      // constrained random mix
      for (int i = 0; i < 30; i++) begin
         int len = 1 + int'($urandom % 30);
         int ncol = int'($urandom % 4);
         int pos = int'($urandom % len);
         bit sm = bit'($urandom % 2);
         do_frame(len, sm, ncol, pos, "R7 random");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule